// File: doc/BRIEF.md
# Shared-Bus Arbiter with Last-Owner Parking

This block decides which of six masters owns a shared parallel bus with PCI-style handshakes. Each master has an active-low request input and gets an active-low grant output. The arbiter also watches the bus cycle-framing signal (FRAME#) and the initiator-ready signal (IRDY#). From these it finds where transactions start, where they end and when the bus is idle. It keeps at most one grant asserted at any time. Grants are handed out in round-robin order, and ownership changes only when the bus allows it.

When no master is requesting and the bus is idle, the grant stays parked on the master that most recently started a transaction. A master can see its grant at one edge and start a transaction just as the arbiter withdraws that grant. The arbiter treats this as a legal start, gives the grant back to that master and records it as the new park target. A parked master that raises its own request keeps the bus and stays the park target.

Every input is sampled on the rising clock edge. Grants come straight from flops, so the grant outputs change one cycle after the inputs that caused the change.

Top module: `pci_park_arbiter`

## Requirements
- R1: While rst_n is sampled low, all grant outputs are driven high (deasserted) from the next cycle on, and master 0 becomes the last-active master.
- R2: At most one bit of gnt_n is low in any cycle.
- R3: When the grant passes from one master to a different master, at least one cycle with all of gnt_n high comes between the two grants.
- R4: If the bus is idle (FRAME# and IRDY# both high) and no request is low, the grant goes to the last-active master and stays there. Right after reset this is master 0, so gnt_n = 6'b111110.
- R5: Among competing requests, the winner is the first requesting master after the most recently granted master, counting upward from index 0 to 5 and wrapping from 5 back to 0.
- R6: After the first cycle of a transaction, while FRAME# is sampled low, the grant output does not change, whatever the requests are.
- R7: Suppose FRAME# is sampled low after being high, and the grant was withdrawn at the edge before. The master that held the grant in the cycle before that withdrawal gets its grant back one cycle later.
- R8: A master whose grant was asserted in the cycle in which it could sample the start of a transaction becomes the last-active master. Later idle periods with no requests park the grant on that master.
- R9: If the parked master raises its request and no other master requests, it keeps its grant without a gap and remains the last-active master.
- R10: New grant decisions are made only while FRAME# is sampled high. This covers an idle bus and the final data phase, which is FRAME# high with IRDY# low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_n | input | 6 | Request per master, active low, bit i = master i |
| frame_n | input | 1 | FRAME# as seen on the bus, active low |
| irdy_n | input | 1 | IRDY# as seen on the bus, active low |
| gnt_n | output | 6 | Grant per master, active low, bit i = master i |

## Verification
A grant decision uses the inputs sampled at one rising edge and appears on gnt_n just after that edge. The bench therefore drives new inputs on the falling edge and checks gnt_n at the falling edge one full cycle later. A transaction start, including a start during a withdrawal race, is credited to the grant that was visible one cycle earlier still. The bench's reference model carries its own one-cycle-delayed copy of the grant for this, so a re-grant caused by a race is expected exactly one cycle after FRAME# is first sampled low. A gap is expected one cycle after a competing request is seen, and the new grant one cycle after that.

// File: rtl/pci_park_pkg.sv
package pci_park_pkg;

   // Bus phase as seen at one rising edge
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,   // FRAME# high, IRDY# high
      PH_FINAL = 2'd1,   // FRAME# high, IRDY# low: last data phase
      PH_START = 2'd2,   // FRAME# newly low
      PH_BUSY  = 2'd3    // FRAME# low for more than one edge
   } bus_phase_e;

   function automatic logic phase_allows_decision(input bus_phase_e ph);
      return (ph == PH_IDLE) || (ph == PH_FINAL);
   endfunction

endpackage

// File: rtl/pci_park_busmon.sv
module pci_park_busmon
   import pci_park_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_n,
   input  logic       irdy_n,
   output bus_phase_e phase
);

   logic frame_prev_q;
   logic frame_now;

   assign frame_now = ~frame_n;

   always_ff @(posedge clk) begin
      if (!rst_n) frame_prev_q <= 1'b0;
      else        frame_prev_q <= frame_now;
   end

   always_comb begin
      if (frame_now && !frame_prev_q) phase = PH_START;
      else if (frame_now)             phase = PH_BUSY;
      else if (!irdy_n)               phase = PH_FINAL;
      else                            phase = PH_IDLE;
   end

   // A busy phase can only follow a cycle in which FRAME# was already low
   AST_BUSY_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_BUSY) |-> frame_prev_q) else $error("busy without prior frame"); // R6

endmodule

// File: rtl/pci_park_rr_pick.sv
module pci_park_rr_pick #(
   parameter int NUM_M = 6,
   localparam int IW = (NUM_M > 1) ? $clog2(NUM_M) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NUM_M-1:0] req,
   input  logic [IW-1:0]    last_idx,
   output logic             any,
   output logic [IW-1:0]    win
);

   // Scan upward from the master after last_idx, wrapping around
   always_comb begin
      any = 1'b0;
      win = '0;
      for (int off = 1; off <= NUM_M; off++) begin
         int cand;
         cand = int'(last_idx) + off;
         if (cand >= NUM_M) cand = cand - NUM_M;
         if (!any && req[cand]) begin
            any = 1'b1;
            win = IW'(cand);
         end
      end
   end

   AST_WIN_IS_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> req[win]) else $error("winner not requesting"); // R5
   AST_ANY_MATCHES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      any == (|req)) else $error("request flag mismatch"); // R5

endmodule

// File: rtl/pci_park_grant_ctl.sv
module pci_park_grant_ctl
   import pci_park_pkg::*;
#(
   parameter int NUM_M = 6,
   localparam int IW = (NUM_M > 1) ? $clog2(NUM_M) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  bus_phase_e       phase,
   input  logic             req_any,
   input  logic [IW-1:0]    win_idx,
   output logic [NUM_M-1:0] gnt_q,
   output logic [IW-1:0]    ptr_q
);

   logic [NUM_M-1:0] gnt_d1_q;      // grant driven one cycle earlier
   logic [IW-1:0]    last_q;        // last-active (park) master
   logic [NUM_M-1:0] gnt_nx;
   logic [IW-1:0]    last_nx;
   logic [IW-1:0]    ptr_nx;
   logic [IW-1:0]    tgt_idx;
   logic [IW-1:0]    owner_idx;
   logic [IW-1:0]    starter_idx;
   logic             owner_vld;
   logic             starter_vld;

   function automatic logic [IW-1:0] enc(input logic [NUM_M-1:0] v);
      logic [IW-1:0] r;
      r = '0;
      for (int i = 0; i < NUM_M; i++)
         if (v[i]) r = IW'(i);
      return r;
   endfunction

   function automatic logic [NUM_M-1:0] dec(input logic [IW-1:0] i);
      logic [NUM_M-1:0] r;
      r = '0;
      for (int k = 0; k < NUM_M; k++)
         if (IW'(k) == i) r[k] = 1'b1;
      return r;
   endfunction

   assign owner_vld   = |gnt_q;
   assign owner_idx   = enc(gnt_q);
   assign starter_vld = |gnt_d1_q;
   assign starter_idx = enc(gnt_d1_q);
   assign tgt_idx     = req_any ? win_idx : last_q;

   always_comb begin
      gnt_nx  = gnt_q;
      last_nx = last_q;
      ptr_nx  = ptr_q;
      unique case (phase)
         PH_START: begin
            // Credit the start to the master that saw its grant one edge ago
            if (starter_vld) begin
               gnt_nx  = dec(starter_idx);
               last_nx = starter_idx;
               ptr_nx  = starter_idx;
            end
         end
         PH_BUSY: begin
            gnt_nx = gnt_q;
         end
         default: begin
            if (!owner_vld) begin
               gnt_nx = dec(tgt_idx);
               ptr_nx = tgt_idx;
            end else if (owner_idx != tgt_idx) begin
               gnt_nx = '0;   // dead cycle before a hand-over
            end
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gnt_q    <= '0;
         gnt_d1_q <= '0;
         last_q   <= '0;
         ptr_q    <= IW'(NUM_M - 1);
      end else begin
         gnt_q    <= gnt_nx;
         gnt_d1_q <= gnt_q;
         last_q   <= last_nx;
         ptr_q    <= ptr_nx;
      end
   end

   AST_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_q)) else $error("more than one grant"); // R2
   AST_GAP_ON_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
      ((|gnt_q) && (|gnt_d1_q)) |-> (gnt_q == gnt_d1_q)) else $error("no gap"); // R3
   AST_HOLD_IN_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_BUSY) |=> (gnt_q == $past(gnt_q))) else $error("grant moved mid transfer"); // R6
   AST_RACE_REGRANT: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase == PH_START) && !(|gnt_q) && (|gnt_d1_q)) |=> (gnt_q == $past(gnt_d1_q)))
      else $error("race not re-granted"); // R7
   AST_PARK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase == PH_IDLE) && !req_any && (gnt_q == dec(last_q))) |=> $stable(gnt_q))
      else $error("park moved"); // R4
   AST_NEW_GRANT_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      ((|gnt_nx) && (gnt_nx != gnt_q)) |-> (phase_allows_decision(phase) || phase == PH_START))
      else $error("decision mid transfer"); // R10

endmodule

// File: rtl/pci_park_arbiter.sv
module pci_park_arbiter
   import pci_park_pkg::*;
#(
   parameter int NUM_MASTERS = 6,
   localparam int IW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_MASTERS-1:0] req_n,
   input  logic                   frame_n,
   input  logic                   irdy_n,
   output logic [NUM_MASTERS-1:0] gnt_n
);

   if (NUM_MASTERS < 2 || NUM_MASTERS > 32) begin : g_bad_count
      $error("NUM_MASTERS must lie between 2 and 32");
   end

   bus_phase_e             phase;
   logic [NUM_MASTERS-1:0] req;
   logic [NUM_MASTERS-1:0] gnt_q;
   logic [IW-1:0]          ptr_q;
   logic [IW-1:0]          win_idx;
   logic                   req_any;

   assign req   = ~req_n;
   assign gnt_n = ~gnt_q;

   pci_park_busmon u_busmon (
      .clk     (clk),
      .rst_n   (rst_n),
      .frame_n (frame_n),
      .irdy_n  (irdy_n),
      .phase   (phase)
   );

   pci_park_rr_pick #(.NUM_M(NUM_MASTERS)) u_pick (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .last_idx (ptr_q),
      .any      (req_any),
      .win      (win_idx)
   );

   pci_park_grant_ctl #(.NUM_M(NUM_MASTERS)) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .phase   (phase),
      .req_any (req_any),
      .win_idx (win_idx),
      .gnt_q   (gnt_q),
      .ptr_q   (ptr_q)
   );

   AST_RESET_CLEARS: assert property (@(posedge clk)
      !rst_n |=> (gnt_n == '1)) else $error("grant after reset"); // R1

endmodule

// File: tb/tb_pci_park_arbiter.sv
module tb_pci_park_arbiter;

   localparam int NM = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NM-1:0] req_n = '1;
   logic          frame_n = 1'b1;
   logic          irdy_n = 1'b1;
   logic [NM-1:0] gnt_n;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // Reference model state
   int m_gnt, m_d1, m_last, m_ptr;
   bit m_fprev;

   always #2.5 clk = ~clk;

   pci_park_arbiter #(.NUM_MASTERS(NM)) dut (
      .clk(clk), .rst_n(rst_n), .req_n(req_n),
      .frame_n(frame_n), .irdy_n(irdy_n), .gnt_n(gnt_n)
   );

   function automatic int rr_first(input logic [NM-1:0] rq, input int after);
      for (int off = 1; off <= NM; off++) begin
         int c = (after + off) % NM;
         if (rq[c]) return c;
      end
      return -1;
   endfunction

   function automatic logic [NM-1:0] exp_n(input int g);
      return (g < 0) ? '1 : ~(NM'(1) << g);
   endfunction

   task automatic model(input logic [NM-1:0] rq, input bit fr, input bit in_rst);
      int ng, tgt;
      if (in_rst) begin
         m_gnt = -1; m_d1 = -1; m_last = 0; m_ptr = NM - 1; m_fprev = 0;
         return;
      end
      ng = m_gnt;
      if (fr && !m_fprev) begin
         if (m_d1 >= 0) begin ng = m_d1; m_last = m_d1; m_ptr = m_d1; end
      end else if (!fr) begin
         tgt = rr_first(rq, m_ptr);
         if (tgt < 0) tgt = m_last;
         if (m_gnt < 0) begin ng = tgt; m_ptr = tgt; end
         else if (m_gnt != tgt) ng = -1;
      end
      m_d1 = m_gnt;
      m_gnt = ng;
      m_fprev = fr;
   endtask

   task automatic step(input logic [NM-1:0] rq, input bit fr, input bit ir);
      req_n = ~rq; frame_n = ~fr; irdy_n = ~ir;
      model(rq, fr, !rst_n);
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [NM-1:0] expv);
      checks++;
      if (gnt_n !== expv) begin
         fails++;
         $display("FAIL %s: gnt_n=%b expected %b", tag, gnt_n, expv);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [NM-1:0] prev_obs;
      void'($urandom(32'd20240611));
      @(negedge clk);
      // R1: reset
      step('0, 0, 0); step('0, 0, 0);
      chk("R1 reset", 6'b111111);
      rst_n = 1'b1;
      // R4: park on master 0 after reset
      step('0, 0, 0);            chk("R4 park after reset", 6'b111110);
      // R3 / R5: master 3 requests
      step(6'b001000, 0, 0);     chk("R3 gap", 6'b111111);
      step(6'b001000, 0, 0);     chk("R5 grant 3", 6'b110111);
      step(6'b001000, 0, 0);     chk("R5 hold 3", 6'b110111);
      step('0, 1, 0);            chk("R8 start by 3", 6'b110111);
      step(6'b100000, 1, 1);     chk("R6 hold mid transfer", 6'b110111);
      step(6'b100000, 0, 1);     chk("R10 final phase decision", 6'b111111);
      step('0, 0, 0);            chk("R8 park on 3", 6'b110111);
      // R7: grant withdrawal race
      step(6'b000010, 0, 0);     chk("R3 withdraw", 6'b111111);
      step(6'b000010, 1, 0);     chk("R7 race regrant", 6'b110111);
      step(6'b000010, 1, 1);     chk("R6 hold after race", 6'b110111);
      step('0, 0, 1);            chk("R10 final no req", 6'b110111);
      step('0, 0, 0);            chk("R8 park after race", 6'b110111);
      // R9: parked master requests
      step(6'b001000, 0, 0);     chk("R9 parked request", 6'b110111);
      step(6'b001000, 0, 0);     chk("R9 parked hold", 6'b110111);
      step(6'b001000, 1, 0);     chk("R9 parked start", 6'b110111);
      step('0, 0, 1);
      step('0, 0, 0);            chk("R9 stays park", 6'b110111);
      // R5: round robin after 3 among 0,2,4
      step(6'b010101, 0, 0);     chk("R3 gap rr", 6'b111111);
      step(6'b010101, 0, 0);     chk("R5 rr picks 4", 6'b101111);
      step(6'b000101, 0, 0);     chk("R3 gap wrap", 6'b111111);
      step(6'b000101, 0, 0);     chk("R5 rr wraps to 0", 6'b111110);
      // Random phase against the reference model
      prev_obs = gnt_n;
      for (int n = 0; n < 4000; n++) begin
         logic [NM-1:0] rq;
         bit fr, ir;
         rq = NM'($urandom & $urandom);
         fr = ($urandom % 3) == 0;
         ir = ($urandom % 2) == 0;
         step(rq, fr, ir);
         chk("R5 model", exp_n(m_gnt));
         checks++;
         if ($countones(~gnt_n) > 1) begin
            fails++;
            $display("FAIL R2: gnt_n=%b expected at most one low", gnt_n);
         end
         checks++;
         if (gnt_n != '1 && prev_obs != '1 && gnt_n != prev_obs) begin
            fails++;
            $display("FAIL R3: gnt_n=%b after %b expected a gap", gnt_n, prev_obs);
         end
         prev_obs = gnt_n;
      end
      finish_run();
   end

endmodule